// File: doc/BRIEF.md
# Vector Lane Exchange Unit

This unit lets each lane of a wide vector take an operand from another lane, but only inside fixed groups. In the two quad modes the lanes form groups of four that stand for a 2×2 block of pixels. Each lane takes the value of its horizontal or vertical partner and gets back the screen-space difference for its row or column, which is what derivative instructions need. In the two row-shift modes each lane takes the value of the lane a programmable distance away, inside its own 16-lane row. It then adds that operand to its own value.

Sources that would cross a row edge supply zero, and so do sources in lanes that are masked off. Lanes that are masked off produce zero on both outputs. Every cycle the unit samples its inputs and presents the result one clock later. It has no handshake, so an issue pipeline can drive it directly.

Top module: `lane_xchg`

## Requirements
- R1: While rst_ni is low, opnd_o and sum_o are all zeros.
- R2: Outputs reflect the inputs sampled at the previous rising edge of clk_i, and they do not change between edges.
- R3: Lane l occupies bits [l*DW +: DW] of each vector. Quads are lanes 4q..4q+3, in the order top-left, top-right, bottom-left, bottom-right. In mode 0 (horizontal difference), the operand of lane l is the value of lane l^1. Both lanes of a quad row get a sum equal to right minus left, modulo 2^DW.
- R4: In mode 1 (vertical difference), the operand of lane l is the value of lane l^2. Both lanes of a quad column get a sum equal to bottom minus top, modulo 2^DW.
- R5: In mode 2 (shift right), the operand of lane l comes from lane l−shift_i in the same 16-lane row (lanes 16r..16r+15). The sum is the lane's own value plus the operand, modulo 2^DW.
- R6: In mode 3 (shift left), the operand of lane l comes from lane l+shift_i in the same 16-lane row. The sum is own value plus operand.
- R7: In a shift mode, a source position outside the lane's 16-lane row supplies zero, so the sum equals the lane's own value.
- R8: In a shift mode, a source lane whose exec_i bit is 0 supplies zero.
- R9: A lane whose exec_i bit is 0 outputs zero on both opnd_o and sum_o, in every mode.
- R10: A shift_i of 0 makes a shift-mode lane source itself, so the sum is twice its value. The quad modes ignore shift_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| data_i | input | LANES*DW | Lane values, lane l at [l*DW +: DW] |
| exec_i | input | LANES | Per-lane active mask |
| mode_i | input | 2 | 0 horizontal diff, 1 vertical diff, 2 shift right, 3 shift left |
| shift_i | input | ROW_LG | Shift distance within a row |
| opnd_o | output | LANES*DW | Sourced operand per lane, registered |
| sum_o | output | LANES*DW | Difference (quad modes) or own plus operand (shift modes), registered |

## Verification
The bench builds the unit with 32 lanes of 8 bits. This keeps two rows and eight quads, so both row edges and quad boundaries away from lane 0 are exercised. The bench sweeps every mode against every one of the 16 shift values, under several data patterns and several exec masks. Every lane is compared against an arithmetic model. With 8-bit lanes, the modular wrap of the differences and sums is reached often.

// File: rtl/lane_xchg_pkg.sv
package lane_xchg_pkg;
  typedef enum logic [1:0] {
    XM_DDX = 2'd0,
    XM_DDY = 2'd1,
    XM_SHR = 2'd2,
    XM_SHL = 2'd3
  } xmode_e;
endpackage

// File: rtl/lane_xchg_quad.sv
module lane_xchg_quad #(
  parameter int DW = 16
) (
  input  logic [4*DW-1:0] d_i,
  input  logic            vert_i,
  output logic [4*DW-1:0] opnd_o,
  output logic [4*DW-1:0] diff_o
);
  always_comb begin
    opnd_o = '0;
    diff_o = '0;
    for (int i = 0; i < 4; i++) begin
      int row0;
      int col0;
      row0 = i & 2;
      col0 = i & 1;
      if (vert_i) begin
        opnd_o[i*DW +: DW] = d_i[(i ^ 2)*DW +: DW];
        diff_o[i*DW +: DW] = d_i[(col0 + 2)*DW +: DW] - d_i[col0*DW +: DW];
      end else begin
        opnd_o[i*DW +: DW] = d_i[(i ^ 1)*DW +: DW];
        diff_o[i*DW +: DW] = d_i[(row0 + 1)*DW +: DW] - d_i[row0*DW +: DW];
      end
    end
  end
endmodule

// File: rtl/lane_xchg_row.sv
module lane_xchg_row #(
  parameter int DW     = 16,
  parameter int ROW_LG = 4,
  localparam int ROW   = 1 << ROW_LG
) (
  input  logic [ROW*DW-1:0] d_i,
  input  logic [ROW-1:0]    ex_i,
  input  logic [ROW_LG-1:0] shift_i,
  input  logic              left_i,
  output logic [ROW*DW-1:0] opnd_o
);
  always_comb begin
    opnd_o = '0;
    for (int j = 0; j < ROW; j++) begin
      int src;
      src = left_i ? j + int'(shift_i) : j - int'(shift_i);
      // out-of-row or masked source supplies zero
      if (src >= 0 && src < ROW) begin
        if (ex_i[src]) opnd_o[j*DW +: DW] = d_i[src*DW +: DW];
      end
    end
  end
endmodule

// File: rtl/lane_xchg.sv
module lane_xchg
  import lane_xchg_pkg::*;
#(
  parameter int LANES  = 64,
  parameter int DW     = 16,
  parameter int ROW_LG = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [LANES*DW-1:0] data_i,
  input  logic [LANES-1:0]    exec_i,
  input  logic [1:0]          mode_i,
  input  logic [ROW_LG-1:0]   shift_i,
  output logic [LANES*DW-1:0] opnd_o,
  output logic [LANES*DW-1:0] sum_o
);
  localparam int ROW   = 1 << ROW_LG;
  localparam int QUADS = LANES / 4;
  localparam int ROWS  = LANES / ROW;

  logic                vert;
  logic                left;
  logic                quad_mode;
  logic [LANES*DW-1:0] q_op, q_diff, r_op;
  logic [LANES*DW-1:0] nxt_op, nxt_sum;

  assign vert      = (mode_i == XM_DDY);
  assign left      = (mode_i == XM_SHL);
  assign quad_mode = (mode_i == XM_DDX) || (mode_i == XM_DDY);

  for (genvar q = 0; q < QUADS; q++) begin : g_quad
    lane_xchg_quad #(.DW(DW)) u_quad (
      .d_i    (data_i[q*4*DW +: 4*DW]),
      .vert_i (vert),
      .opnd_o (q_op[q*4*DW +: 4*DW]),
      .diff_o (q_diff[q*4*DW +: 4*DW])
    );
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    lane_xchg_row #(.DW(DW), .ROW_LG(ROW_LG)) u_row (
      .d_i     (data_i[r*ROW*DW +: ROW*DW]),
      .ex_i    (exec_i[r*ROW +: ROW]),
      .shift_i (shift_i),
      .left_i  (left),
      .opnd_o  (r_op[r*ROW*DW +: ROW*DW])
    );
  end

  always_comb begin
    nxt_op  = '0;
    nxt_sum = '0;
    for (int l = 0; l < LANES; l++) begin
      if (exec_i[l]) begin
        if (quad_mode) begin
          nxt_op[l*DW +: DW]  = q_op[l*DW +: DW];
          nxt_sum[l*DW +: DW] = q_diff[l*DW +: DW];
        end else begin
          nxt_op[l*DW +: DW]  = r_op[l*DW +: DW];
          nxt_sum[l*DW +: DW] = data_i[l*DW +: DW] + r_op[l*DW +: DW];
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      opnd_o <= '0;
      sum_o  <= '0;
    end else begin
      opnd_o <= nxt_op;
      sum_o  <= nxt_sum;
    end
  end
endmodule

// File: rtl/lane_xchg_chk.sv
module lane_xchg_chk
  import lane_xchg_pkg::*;
#(
  parameter int LANES  = 64,
  parameter int DW     = 16,
  parameter int ROW_LG = 4
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [LANES*DW-1:0] data_i,
  input logic [LANES-1:0]    exec_i,
  input logic [1:0]          mode_i,
  input logic [ROW_LG-1:0]   shift_i,
  input logic [LANES*DW-1:0] opnd_o,
  input logic [LANES*DW-1:0] sum_o
);
  logic [LANES*DW-1:0] off_m;
  logic [DW-1:0] d0, d1, d2, dtop, o0, o1, o2, otop, s0, s1, s2, stop;

  always_comb begin
    for (int l = 0; l < LANES; l++) off_m[l*DW +: DW] = {DW{~exec_i[l]}};
  end

  assign d0   = data_i[0 +: DW];
  assign d1   = data_i[DW +: DW];
  assign d2   = data_i[2*DW +: DW];
  assign dtop = data_i[(LANES-1)*DW +: DW];
  assign o0   = opnd_o[0 +: DW];
  assign o1   = opnd_o[DW +: DW];
  assign o2   = opnd_o[2*DW +: DW];
  assign otop = opnd_o[(LANES-1)*DW +: DW];
  assign s0   = sum_o[0 +: DW];
  assign s1   = sum_o[DW +: DW];
  assign s2   = sum_o[2*DW +: DW];
  assign stop = sum_o[(LANES-1)*DW +: DW];

  assert_inactive_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> (((opnd_o | sum_o) & $past(off_m)) == '0));

  assert_ddx_pair_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(mode_i) == XM_DDX && $past(exec_i[1:0]) == 2'b11)
    |-> (s0 == s1 && o0 == $past(d1) && o1 == $past(d0)));

  assert_ddy_col_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(mode_i) == XM_DDY && $past(exec_i[0]) && $past(exec_i[2]))
    |-> (s0 == s2 && o0 == $past(d2) && o2 == $past(d0)));

  assert_row_edge_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(mode_i) == XM_SHR && $past(shift_i) != '0)
    |-> (o0 == '0));

  assert_row_sum_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(mode_i[1]) && $past(exec_i[LANES-1]))
    |-> (stop == DW'($past(dtop) + otop)));
endmodule

bind lane_xchg lane_xchg_chk #(.LANES(LANES), .DW(DW), .ROW_LG(ROW_LG)) u_chk (.*);

// File: tb/lane_xchg_tb.sv
module lane_xchg_tb;
  localparam int LANES = 32;
  localparam int DW    = 8;
  localparam int RLG   = 4;
  localparam int ROW   = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [LANES*DW-1:0] data;
  logic [LANES-1:0]    exec;
  logic [1:0]          mode;
  logic [RLG-1:0]      shift;
  logic [LANES*DW-1:0] opnd, sum;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  lane_xchg #(.LANES(LANES), .DW(DW), .ROW_LG(RLG)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .data_i(data), .exec_i(exec),
    .mode_i(mode), .shift_i(shift), .opnd_o(opnd), .sum_o(sum)
  );

  function automatic logic [DW-1:0] dv(input int l);
    return data[l*DW +: DW];
  endfunction

  task automatic ref_lane(input int l, output logic [DW-1:0] eo, output logic [DW-1:0] es,
                          output string tag);
    int base, src;
    eo = '0; es = '0;
    if (!exec[l]) begin tag = "R9"; return; end
    if (mode == 2'd0) begin
      base = l & ~1;
      eo = dv(l ^ 1); es = dv(base + 1) - dv(base); tag = "R3";
    end else if (mode == 2'd1) begin
      base = l & ~2;
      eo = dv(l ^ 2); es = dv(base + 2) - dv(base); tag = "R4";
    end else begin
      base = (l / ROW) * ROW;
      src  = (mode == 2'd3) ? l + int'(shift) : l - int'(shift);
      tag  = (mode == 2'd3) ? "R6" : "R5";
      if (shift == 0) tag = "R10";
      if (src < base || src >= base + ROW) tag = "R7";
      else if (!exec[src]) tag = "R8";
      else eo = dv(src);
      es = dv(l) + eo;
    end
  endtask

  task automatic check_all();
    logic [DW-1:0] eo, es;
    string tag;
    for (int l = 0; l < LANES; l++) begin
      ref_lane(l, eo, es, tag);
      checks++;
      if (opnd[l*DW +: DW] !== eo) begin
        fails++;
        $display("FAIL %s opnd lane %0d mode %0d shift %0d: got %0h exp %0h",
                 tag, l, mode, shift, opnd[l*DW +: DW], eo);
      end
      checks++;
      if (sum[l*DW +: DW] !== es) begin
        fails++;
        $display("FAIL %s sum lane %0d mode %0d shift %0d: got %0h exp %0h",
                 tag, l, mode, shift, sum[l*DW +: DW], es);
      end
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout exp completion");
    finish_run();
  end

  initial begin
    logic [LANES*DW-1:0] hold_o, hold_s;
    logic [LANES-1:0] masks [4];
    masks[0] = '1;
    masks[1] = 32'h5555_5555;
    masks[2] = 32'hF0F0_0FF0;
    masks[3] = 32'h9E37_79B9;
    data = '0; exec = '0; mode = '0; shift = '0;
    // R1: reset state
    repeat (3) @(negedge clk);
    data = '1; exec = '1;
    @(negedge clk);
    checks++;
    if (opnd !== '0 || sum !== '0) begin
      fails++;
      $display("FAIL R1 reset: got %0h/%0h exp 0", opnd, sum);
    end
    rst_n = 1'b1;

    for (int p = 0; p < 5; p++) begin
      for (int mi = 0; mi < 4; mi++) begin
        for (int m = 0; m < 4; m++) begin
          for (int s = 0; s < 16; s++) begin
            @(negedge clk);
            for (int l = 0; l < LANES; l++)
              data[l*DW +: DW] = DW'(l * (p * 37 + 13) + p * 91 + (l * l * p));
            exec  = masks[mi];
            mode  = 2'(m);
            shift = 4'(s);
            @(negedge clk);
            check_all();
          end
        end
      end
    end

    // R2: outputs hold between edges after inputs change
    hold_o = opnd; hold_s = sum;
    data = ~data; mode = 2'd2; shift = 4'd3;
    #1;
    checks++;
    if (opnd !== hold_o || sum !== hold_s) begin
      fails++;
      $display("FAIL R2 hold: got %0h exp %0h", opnd, hold_o);
    end
    @(negedge clk);
    check_all();

    // R1: reset reasserted clears outputs
    rst_n = 1'b0;
    #1;
    checks++;
    if (opnd !== '0 || sum !== '0) begin
      fails++;
      $display("FAIL R1 reassert: got %0h/%0h exp 0", opnd, sum);
    end
    finish_run();
  end
endmodule